// File: doc/BRIEF.md
# Real-time clock tick divider and interrupt collector

This block turns a slow reference into a one-second tick and nine periodic ticks (2 Hz and 4 Hz to 512 Hz in powers of two). It stays exact when the reference rate is not a power of two. The reference arrives as a single-cycle pulse `ref_pulse` that is already synchronised to the system clock `clk`. A control register selects one of three reference rates. The same register enables or halts the divider.

The block also gathers its own ticks and two outside events into a status register. The outside events are a stopwatch event and an alarm match, each a one-cycle input pulse. Software clears status bits by writing ones. An enable register of the same layout masks the status bits onto a single interrupt line. All three registers sit on a simple 16-bit register bus. Writes are strobed by `bus_wr`. Reads are combinational from `bus_addr`.

The divider is a two-state machine. In state DIV_IDLE its counters are held at zero. In state DIV_RUN it counts reference pulses. The transition IDLE→RUN is taken when the divider is enabled and the rate field is a valid code. The transition RUN→IDLE is taken when the divider is disabled or the rate field is the reserved code. A write that changes the rate field restarts the counters while the divider stays in RUN.

Top module: `rtc_tick_irq`

## Requirements
- R1: The control register at offset 0x10 holds an enable in bit 7 and a rate code in bits 6:5. Code 0 selects REF_A_HZ (default 32768), code 1 selects REF_B_HZ (32000), code 2 selects REF_C_HZ (38400) and code 3 is reserved. The register reads back these fields, and all other bits read as zero.
- R2: Count the accepted reference pulses within the current second as n (0 to R-1, where R is the selected rate). A 512 Hz tick pulses on `pit_tick[8]` for exactly those pulses where floor((n+1)·512/R) exceeds floor(n·512/R). Every tick output is a one-cycle pulse in the cycle after the reference pulse is sampled.
- R3: Let m be the running count of 512 Hz events within the second. The tick of rate 2^(k+1) (`pit_tick[k]`, k = 0..8) pulses together with the 512 Hz event whenever m is a multiple of 256>>k. `sec_tick` pulses once per R accepted pulses, on the R-th pulse, and all periodic ticks pulse with it. Each second therefore holds exactly 2, 4, … 512 of the respective ticks.
- R4: While the divider is disabled or the rate code is 3, no tick is produced and the count stays at zero. A control write that changes the rate code restarts the count, so the next `sec_tick` comes after exactly R pulses at the new rate.
- R5: The status register at offset 0x14 uses the following bits: bit 0 for the stopwatch event, bit 2 for the alarm event, bit 4 for the 1 Hz tick, bit 7 for the 2 Hz tick, and bits 8 to 15 for the 4 to 512 Hz ticks in rising order. A bit sets in the cycle after its event pulse is sampled, or in the cycle after its tick output pulses. The bits 1, 3, 5 and 6 always read as zero.
- R6: Writing the status register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R7: A status bit that is set by an event in the same cycle as a clearing write stays set.
- R8: The enable register at offset 0x18 is readable and writable and has the same layout as the status register. Bits outside that layout read as zero.
- R9: `irq` is high exactly when some status bit and the enable bit in the same position are both set.
- R10: After reset all three registers read zero, and `irq`, `sec_tick` and `pit_tick` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | One-cycle pulse per reference clock period |
| sw_evt | input | 1 | Stopwatch event pulse |
| alarm_evt | input | 1 | Alarm match pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| sec_tick | output | 1 | One-second tick pulse |
| pit_tick | output | 9 | Periodic ticks; bit k pulses at 2^(k+1) Hz |
| irq | output | 1 | Interrupt request |

## Verification
The hardest point to reach is the end of a second at a reference rate that is not a power of two. There the 512 Hz spacing is uneven, and every slower tick must land on the same pulse as `sec_tick`. The bench gets there by shrinking the three rates to 1024, 1000 and 1200 Hz through parameters. It then feeds whole seconds at each rate, while a division-based model predicts every tick on every cycle. A rate change in the middle of a second is followed by exactly R-1 and then one more pulse. This shows that the restart really cleared the partial count. A clearing write is also placed in the same cycle as an event, to test which side wins.

// File: rtl/rtc_tick_pkg.sv
package rtc_tick_pkg;
    // number of periodic taps: 2 Hz .. 512 Hz
    localparam int N_PIT = 9;
    localparam int DW    = 16;

    // status / enable layout
    localparam int B_SW   = 0;
    localparam int B_ALM  = 2;
    localparam int B_SEC  = 4;
    localparam int B_PIT0 = 7;
    localparam logic [DW-1:0] EVT_MASK = 16'hFF95;

    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    typedef enum logic [1:0] {
        RS_A   = 2'd0,
        RS_B   = 2'd1,
        RS_C   = 2'd2,
        RS_OFF = 2'd3
    } rate_sel_e;
endpackage

// File: rtl/rtc_tick_div.sv
module rtc_tick_div
    import rtc_tick_pkg::*;
#(
    parameter int REF_A_HZ = 32768,
    parameter int REF_B_HZ = 32000,
    parameter int REF_C_HZ = 38400
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  rate_sel_e        rate,
    input  logic             restart,
    input  logic             ref_pulse,
    output logic             sec_tick,
    output logic [N_PIT-1:0] pit_tick
);
    localparam int TOP     = 1 << N_PIT;
    localparam int REF_MAX = (REF_A_HZ > REF_B_HZ)
                           ? ((REF_A_HZ > REF_C_HZ) ? REF_A_HZ : REF_C_HZ)
                           : ((REF_B_HZ > REF_C_HZ) ? REF_B_HZ : REF_C_HZ);
    localparam int ACC_W   = $clog2(REF_MAX + TOP + 1);

    div_state_e        state_q, state_d;
    logic [ACC_W-1:0]  acc_q, acc_sum, period;
    logic [N_PIT-1:0]  cnt_q, tap;
    logic              go, adv, carry, fire;

    assign go = run_en && (rate != RS_OFF);

    always_comb begin
        unique case (rate)
            RS_A:    period = ACC_W'(REF_A_HZ);
            RS_B:    period = ACC_W'(REF_B_HZ);
            RS_C:    period = ACC_W'(REF_C_HZ);
            default: period = ACC_W'(REF_A_HZ);
        endcase
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DIV_IDLE: if (go)  state_d = DIV_RUN;
            DIV_RUN:  if (!go) state_d = DIV_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DIV_IDLE;
        else        state_q <= state_d;
    end

    assign adv     = ref_pulse && (state_q == DIV_RUN) && !restart;
    assign acc_sum = acc_q + ACC_W'(TOP);
    assign carry   = (acc_sum >= period);
    assign fire    = adv && carry;

    // fractional accumulator and 512 Hz event counter
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == DIV_IDLE || restart) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (adv) begin
            acc_q <= carry ? (acc_sum - period) : acc_sum;
            cnt_q <= cnt_q + N_PIT'(carry);
        end
    end

    // tap k fires when the event count reaches a multiple of 2^(N_PIT-1-k)
    for (genvar k = 0; k < N_PIT; k++) begin : g_tap
        localparam int LOW = N_PIT - 1 - k;
        if (LOW == 0) begin : g_top
            assign tap[k] = 1'b1;
        end else begin : g_low
            assign tap[k] = &cnt_q[LOW-1:0];
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pit_tick <= '0;
            sec_tick <= 1'b0;
        end else begin
            pit_tick <= tap & {N_PIT{fire}};
            sec_tick <= fire && (&cnt_q);
        end
    end
endmodule

// File: rtl/rtc_tick_irq_ctl.sv
module rtc_tick_irq_ctl
    import rtc_tick_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_vec,
    input  logic [DW-1:0] clr_vec,
    input  logic          ena_wr,
    input  logic [DW-1:0] ena_wdata,
    output logic [DW-1:0] sts_q,
    output logic [DW-1:0] ena_q,
    output logic          irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
            ena_q <= '0;
        end else begin
            // hardware set wins over a same-cycle clear
            sts_q <= ((sts_q & ~clr_vec) | set_vec) & EVT_MASK;
            if (ena_wr) ena_q <= ena_wdata & EVT_MASK;
        end
    end

    assign irq = |(sts_q & ena_q);
endmodule

// File: rtl/rtc_tick_irq.sv
module rtc_tick_irq
    import rtc_tick_pkg::*;
#(
    parameter int REF_A_HZ = 32768,
    parameter int REF_B_HZ = 32000,
    parameter int REF_C_HZ = 38400,
    parameter int ADDR_W   = 8,
    parameter int CTL_OFS  = 16,
    parameter int STS_OFS  = 20,
    parameter int ENA_OFS  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pulse,
    input  logic              sw_evt,
    input  logic              alarm_evt,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              sec_tick,
    output logic [8:0]        pit_tick,
    output logic              irq
);
    logic          en_q;
    rate_sel_e     rate_q;
    logic          ctl_hit, sts_hit, ena_hit, restart;
    logic [DW-1:0] set_vec, clr_vec, sts_q, ena_q;

    assign ctl_hit = bus_wr && (bus_addr == ADDR_W'(CTL_OFS));
    assign sts_hit = bus_wr && (bus_addr == ADDR_W'(STS_OFS));
    assign ena_hit = bus_wr && (bus_addr == ADDR_W'(ENA_OFS));
    assign restart = ctl_hit && (rate_sel_e'(bus_wdata[6:5]) != rate_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            rate_q <= RS_A;
        end else if (ctl_hit) begin
            en_q   <= bus_wdata[7];
            rate_q <= rate_sel_e'(bus_wdata[6:5]);
        end
    end

    rtc_tick_div #(
        .REF_A_HZ (REF_A_HZ),
        .REF_B_HZ (REF_B_HZ),
        .REF_C_HZ (REF_C_HZ)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en    (en_q),
        .rate      (rate_q),
        .restart   (restart),
        .ref_pulse (ref_pulse),
        .sec_tick  (sec_tick),
        .pit_tick  (pit_tick)
    );

    always_comb begin
        set_vec                        = '0;
        set_vec[B_SW]                  = sw_evt;
        set_vec[B_ALM]                 = alarm_evt;
        set_vec[B_SEC]                 = sec_tick;
        set_vec[B_PIT0+N_PIT-1:B_PIT0] = pit_tick;
    end

    assign clr_vec = sts_hit ? bus_wdata : '0;

    rtc_tick_irq_ctl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .ena_wr    (ena_hit),
        .ena_wdata (bus_wdata),
        .sts_q     (sts_q),
        .ena_q     (ena_q),
        .irq       (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CTL_OFS))      bus_rdata = {8'h00, en_q, rate_q, 5'b0};
        else if (bus_addr == ADDR_W'(STS_OFS)) bus_rdata = sts_q;
        else if (bus_addr == ADDR_W'(ENA_OFS)) bus_rdata = ena_q;
    end
endmodule

// File: rtl/rtc_tick_irq_chk.sv
module rtc_tick_irq_chk #(
    parameter int ADDR_W  = 8,
    parameter int STS_OFS = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_pulse,
    input logic              sw_evt,
    input logic              alarm_evt,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic              sec_tick,
    input logic [8:0]        pit_tick,
    input logic              irq,
    input logic              en_q,
    input logic [15:0]       sts,
    input logic [15:0]       ena
);
    // R3
    sec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> (&pit_tick));

    // R2
    ref_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pit_tick != 9'd0) || sec_tick) |-> $past(ref_pulse));

    // R4
    halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_q, 2) |-> ((pit_tick == 9'd0) && !sec_tick));

    // R6
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(STS_OFS) && bus_wdata == 16'hFFFF &&
         !sw_evt && !alarm_evt && !sec_tick && pit_tick == 9'd0) |=> (sts == 16'h0000));

    // R7
    sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_evt |=> sts[0]);

    // R7
    alm_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_evt |=> sts[2]);

    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ena == 16'h0000) |-> !irq);
endmodule

bind rtc_tick_irq rtc_tick_irq_chk #(
    .ADDR_W  (ADDR_W),
    .STS_OFS (STS_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_pulse (ref_pulse),
    .sw_evt    (sw_evt),
    .alarm_evt (alarm_evt),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sec_tick  (sec_tick),
    .pit_tick  (pit_tick),
    .irq       (irq),
    .en_q      (en_q),
    .sts       (sts_q),
    .ena       (ena_q)
);

// File: tb/rtc_tick_irq_tb.sv
`timescale 1ns/1ps
module rtc_tick_irq_tb;
    localparam int RA = 1024, RB = 1000, RC = 1200;
    localparam logic [7:0] A_CTL = 8'h10, A_STS = 8'h14, A_ENA = 8'h18;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_pulse = 1'b0, sw_evt = 1'b0, alarm_evt = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = A_STS;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        sec_tick, irq;
    logic [8:0]  pit_tick;

    always #2.5 clk = ~clk;

    rtc_tick_irq #(.REF_A_HZ(RA), .REF_B_HZ(RB), .REF_C_HZ(RC)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .sw_evt(sw_evt),
        .alarm_evt(alarm_evt), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sec_tick(sec_tick),
        .pit_tick(pit_tick), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    int c_sec = 0, c_512 = 0, c_2 = 0;

    // behavioural reference model
    bit          m_en;
    bit [1:0]    m_rate;
    int          m_n;
    bit [15:0]   m_sts, m_ena;
    bit [8:0]    m_pit;
    bit          m_sec;
    bit [15:0]   t_set, t_clr;
    bit [8:0]    t_pit;
    bit          t_sec;
    int          t_r, t_m0, t_m1;

    function automatic int ref_of(bit [1:0] r);
        if (r == 2'd1) return RB;
        if (r == 2'd2) return RC;
        return RA;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_rate = 0; m_n = 0; m_sts = 0; m_ena = 0; m_pit = 0; m_sec = 0;
        end else begin
            t_set = '0;
            t_set[0] = sw_evt;
            t_set[2] = alarm_evt;
            t_set[4] = m_sec;
            t_set[15:7] = m_pit;
            t_clr = (bus_wr && bus_addr == A_STS) ? bus_wdata : 16'h0;
            if (bus_wr && bus_addr == A_ENA) m_ena = bus_wdata & 16'hFF95;
            t_pit = '0; t_sec = 0;
            if ((bus_wr && bus_addr == A_CTL && bus_wdata[6:5] != m_rate) ||
                !(m_en && m_rate != 2'd3)) begin
                m_n = 0;
            end else if (ref_pulse) begin
                t_r  = ref_of(m_rate);
                t_m0 = (m_n * 512) / t_r;
                m_n++;
                t_m1 = (m_n * 512) / t_r;
                if (t_m1 > t_m0) begin
                    for (int k = 0; k < 9; k++) t_pit[k] = ((t_m1 % (256 >> k)) == 0);
                    t_sec = (t_m1 == 512);
                end
                if (m_n == t_r) m_n = 0;
            end
            if (bus_wr && bus_addr == A_CTL) begin
                m_en = bus_wdata[7];
                m_rate = bus_wdata[6:5];
            end
            m_sts = ((m_sts & ~t_clr) | t_set) & 16'hFF95;
            m_pit = t_pit;
            m_sec = t_sec;
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk(pit_tick == m_pit, "R2 pit_tick", pit_tick, m_pit);
            chk(sec_tick == m_sec, "R3 sec_tick", sec_tick, m_sec);
            chk(irq == |(m_sts & m_ena), "R9 irq", irq, |(m_sts & m_ena));
            if (bus_addr == A_CTL)
                chk(bus_rdata == {8'h0, m_en, m_rate, 5'b0}, "R1 ctl read", bus_rdata, {8'h0, m_en, m_rate, 5'b0});
            else if (bus_addr == A_STS)
                chk(bus_rdata == m_sts, "R5 sts read", bus_rdata, m_sts);
            else if (bus_addr == A_ENA)
                chk(bus_rdata == m_ena, "R8 ena read", bus_rdata, m_ena);
            if (sec_tick)    c_sec++;
            if (pit_tick[8]) c_512++;
            if (pit_tick[0]) c_2++;
        end
    end

    task automatic cyc(bit rp, bit wr, logic [7:0] a, logic [15:0] wd, bit sw, bit al);
        @(negedge clk);
        ref_pulse = rp; bus_wr = wr; bus_addr = a; bus_wdata = wd; sw_evt = sw; alarm_evt = al;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, A_STS, 16'h0, 0, 0);
    endtask

    task automatic refs(int n);
        for (int i = 0; i < n; i++) begin
            cyc(1, 0, A_STS, 16'h0, 0, 0);
            cyc(0, 0, A_STS, 16'h0, 0, 0);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [15:0] wd);
        cyc(0, 1, a, wd, 0, 0);
        idle(3);
    endtask

    task automatic peek(logic [7:0] a, logic [15:0] exp, string tag);
        cyc(0, 0, a, 16'h0, 0, 0);
        #1 chk(bus_rdata == exp, tag, bus_rdata, exp);
    endtask

    task automatic zero_counts();
        c_sec = 0; c_512 = 0; c_2 = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            finish_run();
        end
    end

    initial begin
        idle(4);
        @(negedge clk) rst_n = 1'b1;
        // R10 reset state
        peek(A_CTL, 16'h0000, "R10 ctl after reset");
        peek(A_STS, 16'h0000, "R10 sts after reset");
        peek(A_ENA, 16'h0000, "R10 ena after reset");
        #1 chk(irq == 1'b0 && sec_tick == 1'b0 && pit_tick == 9'd0, "R10 outputs after reset", {irq, sec_tick, pit_tick}, 0);

        // R3 power-of-two rate, one full second
        wr(A_CTL, 16'h0080); zero_counts(); refs(RA); idle(3);
        chk(c_sec == 1, "R3 rate0 1Hz count", c_sec, 1);
        chk(c_512 == 512, "R3 rate0 512Hz count", c_512, 512);
        chk(c_2 == 2, "R3 rate0 2Hz count", c_2, 2);

        // R3 non-power-of-two rate
        wr(A_CTL, 16'h00A0); zero_counts(); refs(RB); idle(3);
        chk(c_sec == 1, "R3 rate1 1Hz count", c_sec, 1);
        chk(c_512 == 512, "R3 rate1 512Hz count", c_512, 512);
        chk(c_2 == 2, "R3 rate1 2Hz count", c_2, 2);

        // R4 rate change mid-second restarts the count
        wr(A_CTL, 16'h00C0); refs(300);
        wr(A_CTL, 16'h00A0); zero_counts(); refs(RB - 1); idle(3);
        chk(c_sec == 0, "R4 no second before R pulses", c_sec, 0);
        refs(1); idle(3);
        chk(c_sec == 1, "R4 second on R-th pulse", c_sec, 1);

        // R4 halted by disable and by reserved code
        wr(A_CTL, 16'h0020); zero_counts(); refs(50); idle(3);
        chk(c_512 == 0, "R4 disabled no ticks", c_512, 0);
        wr(A_CTL, 16'h00E0); refs(50); idle(3);
        chk(c_512 == 0, "R4 reserved code no ticks", c_512, 0);
        peek(A_CTL, 16'h00E0, "R1 ctl readback");

        // R6 / R5 status handling
        wr(A_STS, 16'hFFFF);
        peek(A_STS, 16'h0000, "R6 clear all");
        cyc(0, 0, A_STS, 16'h0, 1, 0); idle(1);
        peek(A_STS, 16'h0001, "R5 stopwatch bit");
        cyc(0, 0, A_STS, 16'h0, 0, 1); idle(1);
        peek(A_STS, 16'h0005, "R5 alarm bit");
        wr(A_STS, 16'h0001);
        peek(A_STS, 16'h0004, "R6 zero bits untouched");
        // R7 set beats clear
        cyc(0, 1, A_STS, 16'hFFFF, 1, 0); idle(1);
        peek(A_STS, 16'h0001, "R7 set wins over clear");

        // R8 / R9 enable and interrupt
        wr(A_ENA, 16'hFFFF);
        peek(A_ENA, 16'hFF95, "R8 ena layout");
        #1 chk(irq == 1'b1, "R9 irq on enabled bit", irq, 1);
        wr(A_ENA, 16'h0004);
        #1 chk(irq == 1'b0, "R9 irq masked", irq, 0);

        // R5 ticks reach status
        wr(A_STS, 16'hFFFF);
        wr(A_ENA, 16'h0010);
        wr(A_CTL, 16'h0080); refs(RA); idle(3);
        peek(A_STS, 16'hFF90, "R5 tick bits after one second");
        #1 chk(irq == 1'b1, "R9 irq from 1Hz", irq, 1);

        idle(2);
        finish_run();
    end
endmodule